// File: doc/BRIEF.md
# Operand Collector Unit Allocator

This block owns a pool of operand collector units grouped into sets and hands them out to instructions that wait in a row of input staging buffers. Each cycle it looks at the staging buffers in index order and takes the lowest-numbered one that holds an instruction. It then looks for a free unit, visiting the sets in a configured order and taking the lowest free unit inside the first set that has one. The chosen unit records the warp id and the source register numbers. It marks one pending bit for every valid source slot and is bound to the output buffer paired with the staging buffer it came from. The staging buffer is told to pop.

In the cycle after allocation the unit presents a read request that lists its pending slots and their register numbers. Operand arrival is reported by a clear strobe that names a unit and a slot. Once every pending bit of a unit is clear and its bound output buffer reports room, the unit dispatches its warp id to that buffer and returns to the free pool. At most one unit dispatches per cycle, and the lowest-numbered eligible unit wins.

Each unit runs a three-state machine. FREE is the idle state. ARMED lasts exactly one cycle after allocation, and the read request is raised in it. GATHER waits for operands and output room. The transitions are: FREE to ARMED on a grant; ARMED to GATHER when it does not dispatch; ARMED to FREE when it dispatches at once (no pending operands); GATHER to FREE on dispatch.

Top module: `opcoll_alloc`

## Requirements
- R1: After reset every unit is FREE: in_take, rdreq_vld and disp_vld are all zero.
- R2: Only the lowest-indexed staging buffer with in_valid set is considered in a cycle. in_take is one-hot on that buffer when a unit is free, and all zero when no unit is free; higher buffers are not served in that cycle.
- R3: Sets are searched in SET_ORDER (default: set 0, then set 1), lowest free unit first within a set; unit index = set*CU_PER_SET + position; one allocation per cycle.
- R4: On allocation, pending bit k (bit k of rdreq_mask for that unit, k = source slot, 2*MAX_OPS slots) is set exactly for the slots whose in_src_vld bit k is 1, and slot k's register number appears in rdreq_reg.
- R5: rdreq_vld bit c is high only in the single cycle after unit c is allocated, and only if it has pending slots.
- R6: A unit dispatches only when allocated, with no pending bits, and with out_free set for its bound output; disp_out is the index of the staging buffer it was allocated from and disp_warp its warp id.
- R7: A dispatched unit is FREE in the following cycle and can be reallocated, taking a fresh binding.
- R8: At most one dispatch per cycle; among eligible units the lowest index dispatches first.
- R9: A clear strobe naming a FREE unit has no effect: a later allocation of that unit still shows the slot pending.
- R10: With no in_valid bit set, nothing is taken and no unit is allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | NUM_IN | Staging buffer holds an instruction |
| in_warp | input | NUM_IN x WARP_W | Warp id per staging buffer |
| in_src_vld | input | NUM_IN x 2*MAX_OPS | Valid source slots per staging buffer |
| in_src_reg | input | NUM_IN x 2*MAX_OPS x REG_W | Source register numbers per staging buffer |
| in_take | output | NUM_IN | One-hot pop of the staging buffer that was allocated |
| out_free | input | NUM_IN | Output buffer paired with each staging buffer has room |
| clr_vld | input | 1 | Operand arrival strobe |
| clr_cu | input | CU_W | Unit whose operand arrived |
| clr_slot | input | SLOT_W | Source slot that arrived |
| rdreq_vld | output | NUM_CU | Read request per unit (cycle after allocation) |
| rdreq_mask | output | NUM_CU x 2*MAX_OPS | Pending slots per requesting unit |
| rdreq_reg | output | NUM_CU x 2*MAX_OPS x REG_W | Captured register numbers per unit |
| disp_vld | output | 1 | A unit dispatches this cycle |
| disp_cu | output | CU_W | Index of the dispatching unit |
| disp_out | output | OUT_W | Output buffer receiving the dispatch |
| disp_warp | output | WARP_W | Warp id being dispatched |

## Verification
The assertions assume that no staging buffer is popped by anything except in_take. They also assume that operand clears name units that are actually waiting, although a clear aimed at a free unit must stay harmless. Finally, they assume out_free is driven for every output index. The stimulus drives each clear once per pending slot. It raises out_free only when a specific dispatch is predicted, so every dispatch the monitor sees matches a queued expectation in order. It holds in_valid at zero around reset so that the read-request history starts clean.

// File: rtl/opcoll_pkg.sv
package opcoll_pkg;

    // Life cycle of one collector unit
    typedef enum logic [1:0] {
        CU_FREE   = 2'd0,
        CU_ARMED  = 2'd1,
        CU_GATHER = 2'd2
    } cu_state_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/opcoll_first_pick.sv
module opcoll_first_pick #(
    parameter int N     = 4,
    parameter int IDX_W = opcoll_pkg::idx_width(N)
) (
    input  logic [N-1:0]     req,
    output logic [IDX_W-1:0] idx,
    output logic [N-1:0]     grant
);

    always_comb begin
        logic hit;
        hit   = 1'b0;
        idx   = '0;
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (!hit && req[i]) begin
                hit      = 1'b1;
                idx      = IDX_W'(i);
                grant[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/opcoll_free_search.sv
module opcoll_free_search #(
    parameter int NUM_SETS   = 2,
    parameter int CU_PER_SET = 2,
    parameter int SET_W      = opcoll_pkg::idx_width(NUM_SETS),
    parameter int CU_W       = opcoll_pkg::idx_width(NUM_SETS * CU_PER_SET),
    parameter logic [NUM_SETS*SET_W-1:0] SET_ORDER = '0
) (
    input  logic [NUM_SETS*CU_PER_SET-1:0] cu_free,
    output logic                           found,
    output logic [CU_W-1:0]                cu_idx
);

    localparam int LOC_W = opcoll_pkg::idx_width(CU_PER_SET);

    logic [NUM_SETS-1:0]           rank_hit;
    logic [NUM_SETS-1:0][CU_W-1:0] rank_cu;

    for (genvar r = 0; r < NUM_SETS; r++) begin : g_rank
        localparam int SET_ID = int'(SET_ORDER[r*SET_W +: SET_W]);
        logic [LOC_W-1:0]      loc;
        logic [CU_PER_SET-1:0] loc_grant;

        opcoll_first_pick #(.N(CU_PER_SET), .IDX_W(LOC_W)) u_pick (
            .req   (cu_free[SET_ID*CU_PER_SET +: CU_PER_SET]),
            .idx   (loc),
            .grant (loc_grant)
        );

        assign rank_hit[r] = |loc_grant;
        assign rank_cu[r]  = CU_W'(SET_ID * CU_PER_SET) + CU_W'(loc);
    end

    always_comb begin
        found  = 1'b0;
        cu_idx = '0;
        for (int r = 0; r < NUM_SETS; r++) begin
            if (!found && rank_hit[r]) begin
                found  = 1'b1;
                cu_idx = rank_cu[r];
            end
        end
    end

endmodule

// File: rtl/opcoll_unit.sv
module opcoll_unit
    import opcoll_pkg::*;
#(
    parameter int NSRC   = 4,
    parameter int WARP_W = 5,
    parameter int REG_W  = 6,
    parameter int OUT_W  = 1,
    parameter int SLOT_W = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        alloc_en,
    input  logic [WARP_W-1:0]           alloc_warp,
    input  logic [NSRC-1:0]             alloc_src_vld,
    input  logic [NSRC-1:0][REG_W-1:0]  alloc_src_reg,
    input  logic [OUT_W-1:0]            alloc_out,
    input  logic                        clr_en,
    input  logic [SLOT_W-1:0]           clr_slot,
    input  logic                        disp_en,
    output logic                        is_free,
    output logic                        gathered,
    output logic                        rd_req,
    output logic [OUT_W-1:0]            bound_out,
    output logic [WARP_W-1:0]           warp_q,
    output logic [NSRC-1:0]             pend_q,
    output logic [NSRC-1:0][REG_W-1:0]  reg_q
);

    cu_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CU_FREE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CU_FREE:   if (alloc_en) state_d = CU_ARMED;
            CU_ARMED:  state_d = disp_en ? CU_FREE : CU_GATHER;
            CU_GATHER: if (disp_en) state_d = CU_FREE;
            default:   state_d = CU_FREE;
        endcase
    end

    // Captured instruction context and pending operands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bound_out <= '0;
            warp_q    <= '0;
            pend_q    <= '0;
            reg_q     <= '0;
        end else if (alloc_en && state_q == CU_FREE) begin
            bound_out <= alloc_out;
            warp_q    <= alloc_warp;
            pend_q    <= alloc_src_vld;
            reg_q     <= alloc_src_reg;
        end else if (disp_en) begin
            bound_out <= '0;
            warp_q    <= '0;
            pend_q    <= '0;
            reg_q     <= '0;
        end else if (clr_en && state_q != CU_FREE) begin
            pend_q[clr_slot] <= 1'b0;
        end
    end

    // Outputs decoded from state
    always_comb begin
        is_free  = 1'b0;
        rd_req   = 1'b0;
        gathered = 1'b0;
        unique case (state_q)
            CU_FREE:   is_free = 1'b1;
            CU_ARMED: begin
                rd_req   = |pend_q;
                gathered = ~|pend_q;
            end
            CU_GATHER: gathered = ~|pend_q;
            default:   is_free = 1'b1;
        endcase
    end

endmodule

// File: rtl/opcoll_alloc.sv
module opcoll_alloc
    import opcoll_pkg::*;
#(
    parameter int NUM_IN     = 2,
    parameter int NUM_SETS   = 2,
    parameter int CU_PER_SET = 2,
    parameter int MAX_OPS    = 2,
    parameter int WARP_W     = 5,
    parameter int REG_W      = 6,
    parameter int NUM_CU     = NUM_SETS * CU_PER_SET,
    parameter int NSRC       = 2 * MAX_OPS,
    parameter int CU_W       = idx_width(NUM_CU),
    parameter int SLOT_W     = idx_width(NSRC),
    parameter int OUT_W      = idx_width(NUM_IN),
    parameter int SET_W      = idx_width(NUM_SETS),
    parameter logic [NUM_SETS*SET_W-1:0] SET_ORDER = 2'b10
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NUM_IN-1:0]                      in_valid,
    input  logic [NUM_IN-1:0][WARP_W-1:0]          in_warp,
    input  logic [NUM_IN-1:0][NSRC-1:0]            in_src_vld,
    input  logic [NUM_IN-1:0][NSRC-1:0][REG_W-1:0] in_src_reg,
    output logic [NUM_IN-1:0]                      in_take,
    input  logic [NUM_IN-1:0]                      out_free,
    input  logic                                   clr_vld,
    input  logic [CU_W-1:0]                        clr_cu,
    input  logic [SLOT_W-1:0]                      clr_slot,
    output logic [NUM_CU-1:0]                      rdreq_vld,
    output logic [NUM_CU-1:0][NSRC-1:0]            rdreq_mask,
    output logic [NUM_CU-1:0][NSRC-1:0][REG_W-1:0] rdreq_reg,
    output logic                                   disp_vld,
    output logic [CU_W-1:0]                        disp_cu,
    output logic [OUT_W-1:0]                       disp_out,
    output logic [WARP_W-1:0]                      disp_warp
);

    // Input selection: lowest staging buffer holding an instruction
    logic [OUT_W-1:0]  in_idx;
    logic [NUM_IN-1:0] in_grant;

    opcoll_first_pick #(.N(NUM_IN), .IDX_W(OUT_W)) u_in_pick (
        .req   (in_valid),
        .idx   (in_idx),
        .grant (in_grant)
    );

    // Free unit search over the sets
    logic [NUM_CU-1:0] cu_free;
    logic              free_found;
    logic [CU_W-1:0]   free_idx;

    opcoll_free_search #(
        .NUM_SETS   (NUM_SETS),
        .CU_PER_SET (CU_PER_SET),
        .SET_W      (SET_W),
        .CU_W       (CU_W),
        .SET_ORDER  (SET_ORDER)
    ) u_search (
        .cu_free (cu_free),
        .found   (free_found),
        .cu_idx  (free_idx)
    );

    logic alloc_ok;
    assign alloc_ok = (|in_grant) && free_found;
    assign in_take  = alloc_ok ? in_grant : '0;

    // Dispatch selection
    logic [NUM_CU-1:0]             cu_gathered;
    logic [NUM_CU-1:0]             cu_rd;
    logic [NUM_CU-1:0]             cu_ready;
    logic [NUM_CU-1:0]             disp_grant;
    logic [NUM_CU-1:0][OUT_W-1:0]  cu_out;
    logic [NUM_CU-1:0][WARP_W-1:0] cu_warp;
    logic [NUM_CU-1:0][NSRC-1:0]   cu_pend;

    for (genvar c = 0; c < NUM_CU; c++) begin : g_cu
        logic alloc_here;
        logic clr_here;

        assign alloc_here = alloc_ok && (free_idx == CU_W'(c));
        assign clr_here   = clr_vld && (clr_cu == CU_W'(c));

        opcoll_unit #(
            .NSRC   (NSRC),
            .WARP_W (WARP_W),
            .REG_W  (REG_W),
            .OUT_W  (OUT_W),
            .SLOT_W (SLOT_W)
        ) u_unit (
            .clk           (clk),
            .rst_n         (rst_n),
            .alloc_en      (alloc_here),
            .alloc_warp    (in_warp[in_idx]),
            .alloc_src_vld (in_src_vld[in_idx]),
            .alloc_src_reg (in_src_reg[in_idx]),
            .alloc_out     (in_idx),
            .clr_en        (clr_here),
            .clr_slot      (clr_slot),
            .disp_en       (disp_grant[c]),
            .is_free       (cu_free[c]),
            .gathered      (cu_gathered[c]),
            .rd_req        (cu_rd[c]),
            .bound_out     (cu_out[c]),
            .warp_q        (cu_warp[c]),
            .pend_q        (cu_pend[c]),
            .reg_q         (rdreq_reg[c])
        );

        assign cu_ready[c]   = cu_gathered[c] && out_free[cu_out[c]];
        assign rdreq_vld[c]  = cu_rd[c];
        assign rdreq_mask[c] = cu_rd[c] ? cu_pend[c] : '0;
    end

    opcoll_first_pick #(.N(NUM_CU), .IDX_W(CU_W)) u_disp_pick (
        .req   (cu_ready),
        .idx   (disp_cu),
        .grant (disp_grant)
    );

    assign disp_vld  = |disp_grant;
    assign disp_out  = cu_out[disp_cu];
    assign disp_warp = cu_warp[disp_cu];

endmodule

// File: rtl/opcoll_alloc_chk.sv
module opcoll_alloc_chk #(
    parameter int NUM_IN = 2,
    parameter int NUM_CU = 4,
    parameter int OUT_W  = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_IN-1:0] in_valid,
    input logic [NUM_IN-1:0] in_take,
    input logic [NUM_IN-1:0] out_free,
    input logic [NUM_CU-1:0] rdreq_vld,
    input logic              disp_vld,
    input logic [OUT_W-1:0]  disp_out
);

    // R2
    take_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_take));

    // R2
    take_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|in_take) |-> (((in_take & in_valid) == in_take) &&
                        (((in_take - NUM_IN'(1)) & in_valid) == '0)));

    // R5
    rdreq_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rdreq_vld) |-> $past(|in_take));

    // R5
    rdreq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rdreq_vld) |=> ((rdreq_vld & $past(rdreq_vld)) == '0));

    // R3
    rdreq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rdreq_vld));

    // R6
    disp_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_vld |-> out_free[disp_out]);

endmodule

bind opcoll_alloc opcoll_alloc_chk #(
    .NUM_IN (NUM_IN),
    .NUM_CU (NUM_CU),
    .OUT_W  (OUT_W)
) u_chk (.*);

// File: tb/tb_opcoll_alloc.sv
module tb_opcoll_alloc;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [1:0]               in_valid = '0;
    logic [1:0][4:0]          in_warp = '0;
    logic [1:0][3:0]          in_src_vld = '0;
    logic [1:0][3:0][5:0]     in_src_reg = '0;
    logic [1:0]               in_take;
    logic [1:0]               out_free = '0;
    logic                     clr_vld = 1'b0;
    logic [1:0]               clr_cu = '0;
    logic [1:0]               clr_slot = '0;
    logic [3:0]               rdreq_vld;
    logic [3:0][3:0]          rdreq_mask;
    logic [3:0][3:0][5:0]     rdreq_reg;
    logic                     disp_vld;
    logic [1:0]               disp_cu;
    logic                     disp_out;
    logic [4:0]               disp_warp;

    always #2 clk = ~clk;

    opcoll_alloc dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_warp    (in_warp),
        .in_src_vld (in_src_vld),
        .in_src_reg (in_src_reg),
        .in_take    (in_take),
        .out_free   (out_free),
        .clr_vld    (clr_vld),
        .clr_cu     (clr_cu),
        .clr_slot   (clr_slot),
        .rdreq_vld  (rdreq_vld),
        .rdreq_mask (rdreq_mask),
        .rdreq_reg  (rdreq_reg),
        .disp_vld   (disp_vld),
        .disp_cu    (disp_cu),
        .disp_out   (disp_out),
        .disp_warp  (disp_warp)
    );

    int  nchk = 0;
    int  nerr = 0;
    bit  summary_done = 1'b0;
    logic [7:0] exp_q[$];

    task automatic chk_eq(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_disp(input int cu, input int o, input int w);
        exp_q.push_back({2'(cu), 1'(o), 5'(w)});
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
        end
    endtask

    task automatic clear_op(input int cu, input int slot);
        @(negedge clk);
        clr_vld  = 1'b1;
        clr_cu   = 2'(cu);
        clr_slot = 2'(slot);
    endtask

    // Scoreboard monitor: R6 R8 dispatch contents and order
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && disp_vld) begin
                if (exp_q.size() == 0) begin
                    chk_eq("R8 unexpected dispatch", 1, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk_eq("R6 R8 dispatch cu/out/warp", int'({disp_cu, disp_out, disp_warp}), int'(e));
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk_eq("R1 in_take after reset", int'(in_take), 0);
        chk_eq("R1 rdreq_vld after reset", int'(rdreq_vld), 0);
        chk_eq("R1 disp_vld after reset", int'(disp_vld), 0);

        // ---- single instruction, operands arrive, output room gates ----
        @(negedge clk);
        in_valid = 2'b01;
        in_warp[0] = 5'd3;
        in_src_vld[0] = 4'b0101;
        in_src_reg[0][0] = 6'd7;
        in_src_reg[0][2] = 6'd12;
        #1 chk_eq("R2 take input0", int'(in_take), 1);
        @(negedge clk);
        in_valid = '0;
        #1;
        chk_eq("R5 rdreq cycle after alloc", int'(rdreq_vld), 1);
        chk_eq("R4 pending mask", int'(rdreq_mask[0]), 5);
        chk_eq("R4 reg slot0", int'(rdreq_reg[0][0]), 7);
        chk_eq("R4 reg slot2", int'(rdreq_reg[0][2]), 12);
        clear_op(0, 0);
        #1 chk_eq("R5 rdreq only one cycle", int'(rdreq_vld), 0);
        clear_op(0, 2);
        #1 chk_eq("R6 no dispatch while pending", int'(disp_vld), 0);
        @(negedge clk);
        clr_vld = 1'b0;
        #1 chk_eq("R6 no dispatch without room", int'(disp_vld), 0);
        @(negedge clk);
        out_free = 2'b10;
        #1 chk_eq("R6 wrong output room ignored", int'(disp_vld), 0);
        @(negedge clk);
        expect_disp(0, 0, 3);
        out_free = 2'b01;
        @(negedge clk);
        out_free = 2'b00;

        // ---- fill the pool: search order R3 ----
        in_src_vld[0] = 4'b0001;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            in_valid = 2'b01;
            in_warp[0] = 5'(10 + k);
            #1;
            chk_eq("R3 take while units free", int'(in_take), 1);
            if (k > 0) chk_eq("R3 unit order", int'(rdreq_vld), 1 << (k - 1));
        end
        @(negedge clk);
        in_valid = 2'b11;
        in_warp[1] = 5'd30;
        #1;
        chk_eq("R3 last unit", int'(rdreq_vld), 8);
        chk_eq("R2 no take when pool full", int'(in_take), 0);
        @(negedge clk);
        in_valid = '0;

        // ---- free unit 2 and reuse it from input1: R7 ----
        clear_op(2, 0);
        @(negedge clk);
        clr_vld = 1'b0;
        expect_disp(2, 0, 12);
        out_free = 2'b01;
        @(negedge clk);
        out_free = 2'b00;
        in_valid = 2'b10;
        in_warp[1] = 5'd20;
        in_src_vld[1] = 4'b0000;
        #1 chk_eq("R7 freed unit reallocated from input1", int'(in_take), 2);
        @(negedge clk);
        in_valid = '0;
        #1;
        chk_eq("R5 no rdreq without pending", int'(rdreq_vld), 0);
        chk_eq("R6 no dispatch without room", int'(disp_vld), 0);
        @(negedge clk);
        expect_disp(2, 1, 20);
        out_free = 2'b10;
        @(negedge clk);
        out_free = 2'b00;

        // ---- two eligible at once: lowest first R8 ----
        clear_op(3, 0);
        clear_op(1, 0);
        @(negedge clk);
        clr_vld = 1'b0;
        expect_disp(1, 0, 11);
        expect_disp(3, 0, 13);
        out_free = 2'b01;
        @(negedge clk);
        @(negedge clk);
        expect_disp(0, 0, 10);
        clear_op(0, 0);
        @(negedge clk);
        clr_vld = 1'b0;
        @(negedge clk);
        out_free = 2'b00;

        // ---- clear aimed at a free unit R9, idle input R10 ----
        clear_op(0, 1);
        out_free = 2'b11;
        #1 chk_eq("R10 no take when idle", int'(in_take), 0);
        @(negedge clk);
        clr_vld = 1'b0;
        #1;
        chk_eq("R10 no allocation when idle", int'(rdreq_vld), 0);
        chk_eq("R9 no dispatch from free unit", int'(disp_vld), 0);
        @(negedge clk);
        out_free = 2'b00;
        in_valid = 2'b01;
        in_warp[0] = 5'd7;
        in_src_vld[0] = 4'b0010;
        in_src_reg[0][1] = 6'd50;
        #1 chk_eq("R9 take", int'(in_take), 1);
        @(negedge clk);
        in_valid = '0;
        #1;
        chk_eq("R9 slot still pending", int'(rdreq_mask[0]), 2);
        chk_eq("R4 reg slot1", int'(rdreq_reg[0][1]), 50);
        clear_op(0, 1);
        @(negedge clk);
        clr_vld = 1'b0;
        expect_disp(0, 0, 7);
        out_free = 2'b01;
        @(negedge clk);
        out_free = 2'b00;

        repeat (3) @(negedge clk);
        chk_eq("R6 all expected dispatches seen", exp_q.size(), 0);
        summary();
        $finish;
    end

endmodule